// File: doc/BRIEF.md
# Serial Load-Store Lane Controller

This block steers the data-memory port of a bit-serial processor core. The core pulses a start request with the access kind (load or store), the access size and the two low address bits. The block latches these and then follows the core's serial step counter. For stores it raises a shift-enable for exactly as many steps as are needed to push the serial rs2 bits into the lanes picked by the address. For loads it forwards the serial bit stream tapped from the external buffer to the rd output while the access width lasts. After that it fills the remaining steps with zeros or with copies of the sign bit. While an access is in progress it also presents a four-lane byte select and, when built with the check enabled, a misalignment flag.

The operation is a small state machine with four states. IDLE waits for a start request. STORE_SHIFT runs the store shift window. LOAD_PASS forwards valid load bits. LOAD_EXT extends the result. The transitions are as follows:
- IDLE→STORE_SHIFT when start is seen with a store.
- IDLE→LOAD_PASS when start is seen with a load.
- STORE_SHIFT→IDLE on the last shift step.
- LOAD_PASS→LOAD_EXT on the last valid step of a byte or halfword load.
- LOAD_PASS→IDLE on the last step of a word load.
- LOAD_EXT→IDLE on step 31.

Top module: `serial_lsu_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, byte select is 0000 and rd, shift-enable and misalign are all 0.
- R2: During an access, byte select is bit-per-lane: size code 0 (byte) selects only lane addr[1:0]. Code 1 (halfword) selects lanes 0 and 1 when addr[1]=0 and lanes 2 and 3 when addr[1]=1. Code 2 (word) selects all four lanes. The value holds for the whole access.
- R3: A store raises shift-enable on each advancing step while the step count is below 32 − 8·addr[1:0]. That is 32, 24, 16 or 8 steps, and the access then ends.
- R4: During a load, rd equals the tapped bit on steps 0..7 (byte), 0..15 (halfword) or 0..31 (word).
- R5: For a signed load, rd on every later step up to step 31 repeats the last valid tapped bit.
- R6: For an unsigned load, rd is 0 on every step after the valid window.
- R7: With the misalign check enabled, misalign is 1 during an access only for a halfword with addr[0]=1 or a word with addr[1:0]≠0.
- R8: Steps advance only when the step-enable input is high. Cycles with it low change no result, and the access ends after its final step.
- R9: A start request during an access is ignored, together with any change of kind, size, sign or address, until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Begin an access (taken only when idle) |
| i_is_load | input | 1 | 1 = load, 0 = store |
| i_signed | input | 1 | Load result is sign-extended |
| i_size | input | 2 | 0 byte, 1 halfword, 2 word |
| i_addr_lsb | input | 2 | Low two bits of the data address |
| i_step_en | input | 1 | Serial step advances this cycle |
| i_step_cnt | input | 5 | Core serial step counter (0..31) |
| i_tap | input | 1 | Serial bit tapped from the load buffer |
| o_rd | output | 1 | Serial load result bit |
| o_shift_en | output | 1 | Store data shift-in enable |
| o_byte_sel | output | 4 | Per-lane byte select |
| o_misalign | output | 1 | Misaligned access flag |

## Verification
A wrong latched size or address shows up on byte select and misalign in the first step of an access. A wrong state shows up either as a shift-enable count that differs from 32 − 8·addr or as a corrupted rd bit, visible in the step after the bad transition. A sign register that captured the wrong bit spoils every extension step, beginning the step after the valid window closes. A missed return to IDLE leaves byte select non-zero in the cycle after the final step.

// File: rtl/slsu_pkg.sv
package slsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE_SHIFT,
        ST_LOAD_PASS,
        ST_LOAD_EXT
    } state_e;
endpackage

// File: rtl/slsu_lane_decode.sv
module slsu_lane_decode #(
    parameter int LANES       = 4,
    parameter bit CHK_ALIGN   = 1'b1,
    localparam int LSB_W      = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [LSB_W-1:0] lsb,
    output logic [LANES-1:0] sel,
    output logic             misalign
);
    import slsu_pkg::*;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            unique case (size)
                SZ_BYTE: sel[i] = (lsb == LSB_W'(i));
                SZ_HALF: sel[i] = ((lsb >> 1) == LSB_W'(i >> 1));
                default: sel[i] = 1'b1;
            endcase
        end
    end

    generate
        if (CHK_ALIGN) begin : g_align
            always_comb begin
                unique case (size)
                    SZ_BYTE: misalign = 1'b0;
                    SZ_HALF: misalign = lsb[0];
                    default: misalign = |lsb;
                endcase
            end
        end else begin : g_no_align
            assign misalign = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/slsu_window.sv
module slsu_window #(
    parameter int XLEN        = 32,
    localparam int CNT_W      = $clog2(XLEN),
    localparam int LSB_W      = $clog2(XLEN / 8),
    localparam int LW         = CNT_W + 1
) (
    input  logic [1:0]       size,
    input  logic [LSB_W-1:0] lsb,
    input  logic [CNT_W-1:0] cnt,
    output logic             store_on,
    output logic             store_last,
    output logic             load_last,
    output logic             word_last
);
    import slsu_pkg::*;

    logic [LW-1:0] cnt_x;
    logic [LW-1:0] load_len;
    logic [LW-1:0] store_len;

    assign cnt_x     = LW'(cnt);
    assign store_len = LW'(XLEN) - LW'({lsb, 3'b000});

    always_comb begin
        unique case (size)
            SZ_BYTE: load_len = LW'(8);
            SZ_HALF: load_len = LW'(16);
            default: load_len = LW'(XLEN);
        endcase
    end

    assign store_on   = cnt_x < store_len;
    assign store_last = cnt_x == store_len - LW'(1);
    assign load_last  = cnt_x == load_len - LW'(1);
    assign word_last  = cnt_x == LW'(XLEN - 1);
endmodule

// File: rtl/slsu_extend.sv
module slsu_extend (
    input  logic clk,
    input  logic rst_n,
    input  logic pass,
    input  logic ext,
    input  logic step_en,
    input  logic sgn,
    input  logic tap,
    output logic rd
);
    logic sign_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
        end else if (pass && step_en) begin
            sign_q <= tap;
        end
    end

    assign rd = pass ? tap : (ext & sgn & sign_q);
endmodule

// File: rtl/serial_lsu_ctrl.sv
module serial_lsu_ctrl #(
    parameter int XLEN       = 32,
    parameter bit CHK_ALIGN  = 1'b1,
    localparam int LANES     = XLEN / 8,
    localparam int CNT_W     = $clog2(XLEN),
    localparam int LSB_W     = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_start,
    input  logic             i_is_load,
    input  logic             i_signed,
    input  logic [1:0]       i_size,
    input  logic [LSB_W-1:0] i_addr_lsb,
    input  logic             i_step_en,
    input  logic [CNT_W-1:0] i_step_cnt,
    input  logic             i_tap,
    output logic             o_rd,
    output logic             o_shift_en,
    output logic [LANES-1:0] o_byte_sel,
    output logic             o_misalign
);
    import slsu_pkg::*;

    state_e           state_q, state_d;
    logic [1:0]       size_q;
    logic [LSB_W-1:0] lsb_q;
    logic             sgn_q;

    logic             store_on, store_last, load_last, word_last;
    logic [LANES-1:0] sel_raw;
    logic             mis_raw;
    logic             busy, pass, ext;

    // operation fields are captured only when a start is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= 2'd0;
            lsb_q  <= '0;
            sgn_q  <= 1'b0;
        end else if (state_q == ST_IDLE && i_start) begin
            size_q <= i_size;
            lsb_q  <= i_addr_lsb;
            sgn_q  <= i_signed;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (i_start) begin
                    state_d = i_is_load ? ST_LOAD_PASS : ST_STORE_SHIFT;
                end
            end
            ST_STORE_SHIFT: begin
                if (i_step_en && store_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOAD_PASS: begin
                if (i_step_en && load_last) begin
                    state_d = word_last ? ST_IDLE : ST_LOAD_EXT;
                end
            end
            ST_LOAD_EXT: begin
                if (i_step_en && word_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    slsu_window #(.XLEN(XLEN)) u_window (
        .size       (size_q),
        .lsb        (lsb_q),
        .cnt        (i_step_cnt),
        .store_on   (store_on),
        .store_last (store_last),
        .load_last  (load_last),
        .word_last  (word_last)
    );

    slsu_lane_decode #(.LANES(LANES), .CHK_ALIGN(CHK_ALIGN)) u_lanes (
        .size     (size_q),
        .lsb      (lsb_q),
        .sel      (sel_raw),
        .misalign (mis_raw)
    );

    slsu_extend u_extend (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass    (pass),
        .ext     (ext),
        .step_en (i_step_en),
        .sgn     (sgn_q),
        .tap     (i_tap),
        .rd      (o_rd)
    );

    // outputs
    always_comb begin
        busy       = 1'b0;
        pass       = 1'b0;
        ext        = 1'b0;
        o_shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE:        busy = 1'b0;
            ST_STORE_SHIFT: begin
                busy       = 1'b1;
                o_shift_en = i_step_en & store_on;
            end
            ST_LOAD_PASS: begin
                busy = 1'b1;
                pass = 1'b1;
            end
            ST_LOAD_EXT: begin
                busy = 1'b1;
                ext  = 1'b1;
            end
            default:        busy = 1'b0;
        endcase
        o_byte_sel = busy ? sel_raw : '0;
        o_misalign = busy & mis_raw;
    end
endmodule

// File: rtl/serial_lsu_ctrl_chk.sv
module serial_lsu_ctrl_chk (
    input logic                  clk,
    input logic                  rst_n,
    input slsu_pkg::state_e      state,
    input logic                  sgn,
    input logic                  i_step_en,
    input logic                  i_tap,
    input logic                  o_rd,
    input logic                  o_shift_en,
    input logic [3:0]            o_byte_sel,
    input logic                  o_misalign
);
    import slsu_pkg::*;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> (o_byte_sel == 4'b0000 && !o_rd && !o_shift_en && !o_misalign));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(o_byte_sel));

    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_shift_en |-> (i_step_en && state == ST_STORE_SHIFT));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD_PASS |-> o_rd == i_tap);

    // R5
    sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_EXT && $past(state) == ST_LOAD_PASS && sgn) |-> o_rd == $past(i_tap));

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_EXT && !sgn) |-> !o_rd);

    // R7
    misalign_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_misalign |-> (o_byte_sel == 4'b1111 || o_byte_sel == 4'b0011 || o_byte_sel == 4'b1100));
endmodule

bind serial_lsu_ctrl serial_lsu_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .sgn        (sgn_q),
    .i_step_en  (i_step_en),
    .i_tap      (i_tap),
    .o_rd       (o_rd),
    .o_shift_en (o_shift_en),
    .o_byte_sel (o_byte_sel),
    .o_misalign (o_misalign)
);

// File: tb/tb_serial_lsu_ctrl.sv
`timescale 1ns/1ps
module tb_serial_lsu_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_start = 1'b0, i_is_load = 1'b0, i_signed = 1'b0;
    logic [1:0] i_size = 2'd0, i_addr_lsb = 2'd0;
    logic       i_step_en = 1'b0;
    logic [4:0] i_step_cnt = 5'd0;
    logic       i_tap = 1'b0;
    logic       o_rd, o_shift_en, o_misalign;
    logic [3:0] o_byte_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_lsu_ctrl dut (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_is_load(i_is_load),
        .i_signed(i_signed), .i_size(i_size), .i_addr_lsb(i_addr_lsb),
        .i_step_en(i_step_en), .i_step_cnt(i_step_cnt), .i_tap(i_tap),
        .o_rd(o_rd), .o_shift_en(o_shift_en), .o_byte_sel(o_byte_sel),
        .o_misalign(o_misalign)
    );

    // {load, signed, size, lsb, tap data, expected rd, expected sel, expected misalign, expected shift steps}
    localparam int NV = 13;
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'd0, 2'd0, 32'h1234F0B6, 32'hFFFFFFB6, 4'b0001, 1'b0, 6'd0},
        {1'b1, 1'b0, 2'd0, 2'd2, 32'h1234F0B6, 32'h000000B6, 4'b0100, 1'b0, 6'd0},
        {1'b1, 1'b1, 2'd1, 2'd2, 32'h1234F0B6, 32'hFFFFF0B6, 4'b1100, 1'b0, 6'd0},
        {1'b1, 1'b0, 2'd1, 2'd0, 32'h1234F0B6, 32'h0000F0B6, 4'b0011, 1'b0, 6'd0},
        {1'b1, 1'b1, 2'd2, 2'd0, 32'h1234F0B6, 32'h1234F0B6, 4'b1111, 1'b0, 6'd0},
        {1'b1, 1'b1, 2'd0, 2'd3, 32'hA5C38E71, 32'h00000071, 4'b1000, 1'b0, 6'd0},
        {1'b1, 1'b1, 2'd1, 2'd1, 32'hA5C38E71, 32'hFFFF8E71, 4'b0011, 1'b1, 6'd0},
        {1'b1, 1'b1, 2'd2, 2'd2, 32'hA5C38E71, 32'hA5C38E71, 4'b1111, 1'b1, 6'd0},
        {1'b0, 1'b0, 2'd0, 2'd1, 32'hFFFFFFFF, 32'h00000000, 4'b0010, 1'b0, 6'd24},
        {1'b0, 1'b0, 2'd1, 2'd2, 32'hFFFFFFFF, 32'h00000000, 4'b1100, 1'b0, 6'd16},
        {1'b0, 1'b0, 2'd2, 2'd0, 32'hFFFFFFFF, 32'h00000000, 4'b1111, 1'b0, 6'd32},
        {1'b0, 1'b0, 2'd0, 2'd3, 32'hFFFFFFFF, 32'h00000000, 4'b1000, 1'b0, 6'd8},
        {1'b0, 1'b0, 2'd2, 2'd3, 32'hFFFFFFFF, 32'h00000000, 4'b1111, 1'b1, 6'd8}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [80:0] v, input bit gaps, input bit noise, input string tag);
        logic        ld, sg, em;
        logic [1:0]  sz, lb;
        logic [31:0] dat, erd, got;
        logic [3:0]  esel;
        logic [5:0]  esh;
        int          shn;
        {ld, sg, sz, lb, dat, erd, esel, em, esh} = v;
        got = '0;
        shn = 0;
        @(negedge clk);
        i_start = 1'b1; i_is_load = ld; i_signed = sg; i_size = sz; i_addr_lsb = lb;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (gaps && (k % 5 == 2)) begin
                i_step_en = 1'b0;
                i_tap = ~dat[k];
                @(negedge clk);
            end
            i_start = noise;
            if (noise) begin
                i_is_load = ~ld; i_signed = ~sg; i_size = 2'd0; i_addr_lsb = ~lb;
            end
            i_step_cnt = 5'(k);
            i_tap = dat[k];
            i_step_en = 1'b1;
            #1;
            got[k] = o_rd;
            if (o_shift_en) shn++;
            if (k == 0) begin
                chk(o_byte_sel == esel, {"R2 byte select ", tag}, 32'(o_byte_sel), 32'(esel));
                chk(o_misalign == em, {"R7 misalign ", tag}, 32'(o_misalign), 32'(em));
            end
        end
        @(negedge clk);
        i_step_en = 1'b0;
        i_start = 1'b0;
        #1;
        if (ld) begin
            chk(got == erd, {"R4/R5/R6 load result ", tag}, got, erd);
        end else begin
            chk(shn == int'(esh), {"R3 store shift steps ", tag}, 32'(shn), 32'(esh));
            chk(got == 32'h0, {"R1 store rd quiet ", tag}, got, 32'h0);
        end
        chk(o_byte_sel == 4'b0000 && !o_misalign, {"R8 back to idle ", tag},
            32'({o_byte_sel, o_misalign}), 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(o_byte_sel == 4'b0000 && !o_rd && !o_shift_en && !o_misalign, "R1 reset outputs",
            32'({o_byte_sel, o_rd, o_shift_en, o_misalign}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(o_byte_sel == 4'b0000 && !o_rd && !o_shift_en, "R1 idle after reset",
            32'({o_byte_sel, o_rd, o_shift_en}), 32'h0);

        for (int n = 0; n < NV; n++) begin
            run_vec(VEC[n], 1'b0, 1'b0, $sformatf("vec%0d", n));
        end

        // R8 stalled steps change nothing
        run_vec(VEC[2], 1'b1, 1'b0, "signed half with gaps");
        run_vec(VEC[8], 1'b1, 1'b0, "store with gaps");
        // R9 start and field changes ignored during an access
        run_vec(VEC[6], 1'b0, 1'b1, "R9 start ignored while busy");
        run_vec(VEC[3], 1'b1, 1'b1, "R9 unsigned half noisy");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule